// File: doc/BRIEF.md
# Automatic-Retry Transmit Sequencer

This block runs one complete transmit transaction with automatic retries for a low-rate wireless link. A transaction begins on a rising edge of a start pin or on a register write of the transmit-start command. The sequencer then asks an external channel-access unit for a clear-channel decision. If the channel is busy, it asks again, up to a programmable limit. Once the channel is clear, it tells an external transmitter to send the stored frame. While the header goes out, it captures the acknowledgement-request bit and the sequence number.

When the outgoing frame asks for an acknowledgement, the sequencer watches a stream of parsed receive fields for a matching acknowledgement, within a parameterised cycle window. If none arrives in time, the whole channel-access-plus-send sequence is retried, up to a programmable frame-retry limit. Every transaction ends with a 3-bit result code, a one-cycle end pulse, and a sticky end flag that software clears with a read strobe.

Top module: `aretx_ctrl`

## Requirements
- R1: In idle, a transaction starts on a rising edge of `start_pin`, or on a cycle with `cmd_we` high and `cmd_val` equal to 2 (5-bit field). Any other command value has no effect. One cycle later `busy` is 1 and `trac_status` reads 7.
- R2: A start request that arrives while `busy` is high is ignored. The transaction finishes with exactly one end pulse, and no new transaction follows it.
- R3: Each channel-access attempt is a one-cycle `ca_req` pulse. The result is taken from the cycle with `ca_done` high, where `ca_idle` 1 means clear and 0 means busy. A busy result triggers another attempt. The number of attempts per frame is at most the channel-retry limit plus one, where the limit is `max_ca_retries` clamped to 5.
- R4: When all attempts for a frame report busy, the transaction ends with status 3. No frame is sent in that case.
- R5: A clear result produces one `tx_start` pulse. Bit 5 of `tx_fc0` is the acknowledgement-request flag and `tx_dsn` is the sequence number. Both are captured on the cycle with `tx_hdr_valid` high.
- R6: With the acknowledgement-request bit clear, the transaction ends with status 0 on the `tx_done` cycle.
- R7: With the bit set, a received frame is a valid acknowledgement when all of these hold: `rx_valid` is high, `rx_type` equals 3'b010, `rx_seq` equals the captured sequence number, and `rx_fcs_ok` is high. A valid acknowledgement ends the transaction with status 1 if `rx_pending` is set, and 0 otherwise.
- R8: A received frame that fails any of the R7 conditions is ignored and does not restart the timeout.
- R9: Counting the `tx_done` cycle as 0, an acknowledgement is accepted in cycles 1 to `ACK_WAIT_CYC`. In cycle `ACK_WAIT_CYC` it takes precedence over the expiry.
- R10: On expiry, the channel-access count restarts and a new frame attempt begins. After `max_frame_retries`+1 sends without an acknowledgement, the transaction ends with status 5.
- R11: `end_pulse` lasts one cycle. In the same cycle `busy` falls and `end_flag` sets. `end_flag` stays set until `flag_rd` clears it.
- R12: After reset, `busy`, `end_flag`, `end_pulse`, `ca_req` and `tx_start` are 0, and `trac_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_pin | input | 1 | Start pin, rising edge starts a transaction |
| cmd_we | input | 1 | Command field write strobe |
| cmd_val | input | CMD_W | Command value, 2 = transmit start |
| max_frame_retries | input | FR_W | Frame retry limit |
| max_ca_retries | input | CA_W | Channel-access retry limit, clamped to 5 |
| ca_req | output | 1 | Channel-access attempt request pulse |
| ca_done | input | 1 | Channel-access result valid |
| ca_idle | input | 1 | Channel clear (1) or busy (0) |
| tx_start | output | 1 | Frame send request pulse |
| tx_hdr_valid | input | 1 | Header fields valid |
| tx_fc0 | input | 8 | First frame-control octet being sent |
| tx_dsn | input | SEQ_W | Sequence number being sent |
| tx_done | input | 1 | Frame send complete |
| rx_valid | input | 1 | Received frame fields valid |
| rx_type | input | 3 | Received frame type |
| rx_seq | input | SEQ_W | Received sequence number |
| rx_fcs_ok | input | 1 | Received checksum correct |
| rx_pending | input | 1 | Received frame-pending bit |
| flag_rd | input | 1 | End flag read-clear strobe |
| busy | output | 1 | Transaction in progress |
| trac_status | output | 3 | Result code |
| end_pulse | output | 1 | One-cycle end-of-transaction pulse |
| end_flag | output | 1 | Sticky end-of-transaction flag |

## Verification
Two events can land in the same cycle: arrival of a valid acknowledgement and expiry of the acknowledgement window. The bench provokes this by delivering the acknowledgement exactly `ACK_WAIT_CYC` cycles after the send-done cycle, and then one cycle later. The first case must end with the acknowledgement result. The second must retry the frame and end in NO_ACK when no further acknowledgement comes. Decoy frames with a wrong sequence number, a bad checksum or a non-acknowledgement type are placed inside every window, to confirm they neither end the wait nor restart the timer.

// File: rtl/aretx_pkg.sv
package aretx_pkg;
  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_OK_PEND = 3'd1,
    RES_CA_FAIL = 3'd3,
    RES_NO_ACK  = 3'd5,
    RES_BUSY    = 3'd7
  } result_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CA_WAIT,
    PH_TX_WAIT,
    PH_ACK_WAIT
  } phase_e;

  localparam logic [2:0] FTYPE_ACK     = 3'b010;
  localparam int         ACKREQ_BIT    = 5;
  localparam int         CA_LIMIT_CAP  = 5;
endpackage

// File: rtl/aretx_start_det.sv
module aretx_start_det #(
  parameter int CMD_W = 5,
  parameter logic [CMD_W-1:0] CMD_TX_START = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_val,
  output logic             start
);
  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin;
  end

  assign start = (pin && !pin_q) || (cmd_we && (cmd_val == CMD_TX_START));
endmodule

// File: rtl/aretx_ack_filter.sv
module aretx_ack_filter #(
  parameter int SEQ_W = 8
) (
  input  logic             rx_valid,
  input  logic [2:0]       rx_type,
  input  logic [SEQ_W-1:0] rx_seq,
  input  logic             rx_fcs_ok,
  input  logic [SEQ_W-1:0] want_seq,
  output logic             hit
);
  import aretx_pkg::*;
  assign hit = rx_valid && rx_fcs_ok && (rx_type == FTYPE_ACK) && (rx_seq == want_seq);
endmodule

// File: rtl/aretx_ack_timer.sv
module aretx_ack_timer #(
  parameter int LIMIT = 1350
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear)        cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/aretx_ctrl.sv
module aretx_ctrl #(
  parameter int CMD_W        = 5,
  parameter int FR_W         = 4,
  parameter int CA_W         = 3,
  parameter int SEQ_W        = 8,
  parameter int SYM_CYC      = 25,
  parameter int ACK_SYMS     = 54,
  parameter int ACK_WAIT_CYC = ACK_SYMS * SYM_CYC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_pin,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_val,
  input  logic [FR_W-1:0]  max_frame_retries,
  input  logic [CA_W-1:0]  max_ca_retries,
  output logic             ca_req,
  input  logic             ca_done,
  input  logic             ca_idle,
  output logic             tx_start,
  input  logic             tx_hdr_valid,
  input  logic [7:0]       tx_fc0,
  input  logic [SEQ_W-1:0] tx_dsn,
  input  logic             tx_done,
  input  logic             rx_valid,
  input  logic [2:0]       rx_type,
  input  logic [SEQ_W-1:0] rx_seq,
  input  logic             rx_fcs_ok,
  input  logic             rx_pending,
  input  logic             flag_rd,
  output logic             busy,
  output logic [2:0]       trac_status,
  output logic             end_pulse,
  output logic             end_flag
);
  import aretx_pkg::*;

  localparam logic [CA_W-1:0] CA_CAP = CA_W'(CA_LIMIT_CAP);

  phase_e           phase;
  logic             start;
  logic             ack_hit;
  logic             expired;
  logic             ackreq_q;
  logic [SEQ_W-1:0] dsn_q;
  logic [FR_W-1:0]  fr_cnt;
  logic [CA_W-1:0]  ca_cnt;
  logic [CA_W-1:0]  ca_limit;
  logic             ackreq_now;
  logic             fin;
  result_e          fin_code;
  logic             retry_frame;

  aretx_start_det #(.CMD_W(CMD_W)) u_start (
    .clk(clk), .rst(rst), .pin(start_pin), .cmd_we(cmd_we),
    .cmd_val(cmd_val), .start(start)
  );

  aretx_ack_filter #(.SEQ_W(SEQ_W)) u_filt (
    .rx_valid(rx_valid), .rx_type(rx_type), .rx_seq(rx_seq),
    .rx_fcs_ok(rx_fcs_ok), .want_seq(dsn_q), .hit(ack_hit)
  );

  aretx_ack_timer #(.LIMIT(ACK_WAIT_CYC)) u_timer (
    .clk(clk), .rst(rst),
    .clear(phase == PH_TX_WAIT && tx_done),
    .run(phase == PH_ACK_WAIT),
    .expired(expired)
  );

  assign ca_limit   = (max_ca_retries > CA_CAP) ? CA_CAP : max_ca_retries;
  assign ackreq_now = tx_hdr_valid ? tx_fc0[ACKREQ_BIT] : ackreq_q;

  always_comb begin
    fin         = 1'b0;
    fin_code    = RES_OK;
    retry_frame = 1'b0;
    unique case (phase)
      PH_CA_WAIT: begin
        if (ca_done && !ca_idle && ca_cnt == ca_limit) begin
          fin      = 1'b1;
          fin_code = RES_CA_FAIL;
        end
      end
      PH_TX_WAIT: begin
        if (tx_done && !ackreq_now) begin
          fin      = 1'b1;
          fin_code = RES_OK;
        end
      end
      PH_ACK_WAIT: begin
        if (ack_hit) begin
          fin      = 1'b1;
          fin_code = rx_pending ? RES_OK_PEND : RES_OK;
        end else if (expired) begin
          if (fr_cnt == max_frame_retries) begin
            fin      = 1'b1;
            fin_code = RES_NO_ACK;
          end else begin
            retry_frame = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      busy        <= 1'b0;
      trac_status <= RES_OK;
      ca_req      <= 1'b0;
      tx_start    <= 1'b0;
      end_pulse   <= 1'b0;
      end_flag    <= 1'b0;
      fr_cnt      <= '0;
      ca_cnt      <= '0;
      ackreq_q    <= 1'b0;
      dsn_q       <= '0;
    end else begin
      ca_req    <= 1'b0;
      tx_start  <= 1'b0;
      end_pulse <= 1'b0;
      if (flag_rd) end_flag <= 1'b0;

      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            busy        <= 1'b1;
            trac_status <= RES_BUSY;
            fr_cnt      <= '0;
            ca_cnt      <= '0;
            ackreq_q    <= 1'b0;
            ca_req      <= 1'b1;
            phase       <= PH_CA_WAIT;
          end
        end
        PH_CA_WAIT: begin
          if (ca_done) begin
            if (ca_idle) begin
              tx_start <= 1'b1;
              phase    <= PH_TX_WAIT;
            end else if (!fin) begin
              ca_cnt <= ca_cnt + 1'b1;
              ca_req <= 1'b1;
            end
          end
        end
        PH_TX_WAIT: begin
          if (tx_hdr_valid) begin
            ackreq_q <= tx_fc0[ACKREQ_BIT];
            dsn_q    <= tx_dsn;
          end
          if (tx_done && ackreq_now) phase <= PH_ACK_WAIT;
        end
        PH_ACK_WAIT: begin
          if (retry_frame) begin
            fr_cnt <= fr_cnt + 1'b1;
            ca_cnt <= '0;
            ca_req <= 1'b1;
            phase  <= PH_CA_WAIT;
          end
        end
        default: phase <= PH_IDLE;
      endcase

      if (fin) begin
        end_pulse   <= 1'b1;
        end_flag    <= 1'b1;
        busy        <= 1'b0;
        trac_status <= fin_code;
        phase       <= PH_IDLE;
      end
    end
  end
endmodule

// File: rtl/aretx_ctrl_chk.sv
module aretx_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic [2:0] trac_status,
  input logic       end_pulse,
  input logic       end_flag,
  input logic       ca_req,
  input logic       tx_start
);
  assert_busy_code_R1: assert property (@(posedge clk) disable iff (rst)
    busy |-> trac_status == 3'd7);

  assert_req_in_txn_R5: assert property (@(posedge clk) disable iff (rst)
    (ca_req || tx_start) |-> busy);

  assert_one_action_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ca_req, tx_start, end_pulse}));

  assert_end_single_R11: assert property (@(posedge clk) disable iff (rst)
    end_pulse |=> !end_pulse);

  assert_end_sets_flag_R11: assert property (@(posedge clk) disable iff (rst)
    end_pulse |-> (end_flag && !busy));

  assert_busy_drop_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> end_pulse);

  assert_result_code_R10: assert property (@(posedge clk) disable iff (rst)
    end_pulse |-> (trac_status == 3'd0 || trac_status == 3'd1 ||
                   trac_status == 3'd3 || trac_status == 3'd5));
endmodule

bind aretx_ctrl aretx_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .trac_status(trac_status),
  .end_pulse(end_pulse), .end_flag(end_flag), .ca_req(ca_req), .tx_start(tx_start)
);

// File: tb/tb_aretx_ctrl.sv
`timescale 1ns/1ps
module tb_aretx_ctrl;
  localparam int T = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_pin = 1'b0;
  logic       cmd_we = 1'b0;
  logic [4:0] cmd_val = '0;
  logic [3:0] max_frame_retries = '0;
  logic [2:0] max_ca_retries = '0;
  logic       ca_req, tx_start, busy, end_pulse, end_flag;
  logic [2:0] trac_status;
  logic       ca_done = 1'b0, ca_idle = 1'b0;
  logic       tx_hdr_valid = 1'b0, tx_done = 1'b0;
  logic [7:0] tx_fc0 = '0, tx_dsn = '0;
  logic       rx_valid = 1'b0, rx_fcs_ok = 1'b0, rx_pending = 1'b0;
  logic [2:0] rx_type = '0;
  logic [7:0] rx_seq = '0;
  logic       flag_rd = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] seq_base = 8'h40;

  always #2.5 clk = ~clk;

  aretx_ctrl #(.ACK_WAIT_CYC(T)) dut (
    .clk(clk), .rst(rst), .start_pin(start_pin), .cmd_we(cmd_we), .cmd_val(cmd_val),
    .max_frame_retries(max_frame_retries), .max_ca_retries(max_ca_retries),
    .ca_req(ca_req), .ca_done(ca_done), .ca_idle(ca_idle), .tx_start(tx_start),
    .tx_hdr_valid(tx_hdr_valid), .tx_fc0(tx_fc0), .tx_dsn(tx_dsn), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_type(rx_type), .rx_seq(rx_seq), .rx_fcs_ok(rx_fcs_ok),
    .rx_pending(rx_pending), .flag_rd(flag_rd), .busy(busy), .trac_status(trac_status),
    .end_pulse(end_pulse), .end_flag(end_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_pulses();
    ca_done = 0; tx_hdr_valid = 0; tx_done = 0; rx_valid = 0; cmd_we = 0; flag_rd = 0;
  endtask

  task automatic run_txn(input int mfr, input int mca, input int busy_each, input int ack_at,
                         input bit pend, input bit ackreq, input int ack_delay, input bit use_pin);
    int ca_seen = 0, tx_seen = 0, ends = 0, busy_left, since = -1, tx_cd = -1, cyc = 0;
    int eff, exp_tx, exp_ca, exp_st;
    bit done = 0;
    logic [7:0] seq;
    seq = seq_base;
    seq_base = seq_base + 8'd3;
    max_frame_retries = 4'(mfr);
    max_ca_retries = 3'(mca);
    eff = (mca > 5) ? 5 : mca;
    if (busy_each > eff) begin
      exp_st = 3; exp_tx = 0; exp_ca = eff + 1;
    end else begin
      if (!ackreq) begin
        exp_st = 0; exp_tx = 1;
      end else if (ack_at >= 1 && ack_at <= mfr + 1 && ack_delay <= T) begin
        exp_st = pend ? 1 : 0; exp_tx = ack_at;
      end else begin
        exp_st = 5; exp_tx = mfr + 1;
      end
      exp_ca = exp_tx * (busy_each + 1);
    end

    @(negedge clk);
    if (use_pin) start_pin = 1; else begin cmd_we = 1; cmd_val = 5'd2; end
    @(negedge clk);
    cmd_we = 0;
    chk(busy === 1'b1 && trac_status === 3'd7, "R1 busy/status after start", int'(trac_status), 7);
    busy_left = busy_each;
    while (!done && cyc < 3000) begin
      if (ca_req) begin
        ca_seen++; ca_done = 1; ca_idle = (busy_left == 0);
        if (busy_left > 0) busy_left--;
      end
      if (tx_start) begin
        tx_seen++; busy_left = busy_each; tx_hdr_valid = 1;
        tx_fc0 = ackreq ? 8'h21 : 8'h01; tx_dsn = seq; tx_cd = 3;
      end else if (tx_cd > 0) begin
        tx_cd--;
        if (tx_cd == 0) begin tx_done = 1; since = 0; tx_cd = -1; end
      end else if (since >= 0) begin
        since++;
        // R8 decoys: wrong sequence, bad checksum, wrong frame type
        if (since == 1) begin rx_valid = 1; rx_type = 3'b010; rx_seq = seq ^ 8'h01; rx_fcs_ok = 1; rx_pending = 1; end
        if (since == 2) begin rx_valid = 1; rx_type = 3'b010; rx_seq = seq; rx_fcs_ok = 0; rx_pending = 1; end
        if (since == 3) begin rx_valid = 1; rx_type = 3'b001; rx_seq = seq; rx_fcs_ok = 1; rx_pending = 1; end
        if (since == ack_delay && tx_seen == ack_at) begin
          rx_valid = 1; rx_type = 3'b010; rx_seq = seq; rx_fcs_ok = 1; rx_pending = pend;
        end
      end
      if (cyc == 5 && busy) begin cmd_we = 1; cmd_val = 5'd2; start_pin = 1; end
      if (end_pulse) begin
        ends++; done = 1;
        chk(int'(trac_status) == exp_st, "R4/R6/R7/R10 result code", int'(trac_status), exp_st);
        chk(busy === 1'b0 && end_flag === 1'b1, "R11 end pulse with busy low, flag set", int'(end_flag), 1);
      end
      @(negedge clk);
      clear_pulses();
      cyc++;
    end
    chk(done, "R2 transaction completes", int'(done), 1);
    chk(tx_seen == exp_tx, "R5/R10 frame send count", tx_seen, exp_tx);
    chk(ca_seen == exp_ca, "R3 channel-access attempts", ca_seen, exp_ca);
    chk(end_pulse === 1'b0, "R11 end pulse single cycle", int'(end_pulse), 0);
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && ends == 1, "R2 start during busy ignored", int'(busy), 0);
    chk(end_flag === 1'b1, "R11 end flag sticky", int'(end_flag), 1);
    flag_rd = 1; start_pin = 0;
    @(negedge clk);
    flag_rd = 0;
    chk(end_flag === 1'b0, "R11 end flag read-clear", int'(end_flag), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk(busy === 0 && end_flag === 0 && end_pulse === 0 && ca_req === 0 && tx_start === 0,
        "R12 outputs idle after reset", int'(busy), 0);
    chk(trac_status === 3'd0, "R12 status after reset", int'(trac_status), 0);
    // R1 other command value has no effect
    cmd_we = 1; cmd_val = 5'd3;
    @(negedge clk); cmd_we = 0;
    @(negedge clk);
    chk(busy === 0 && ca_req === 0, "R1 wrong command ignored", int'(busy), 0);

    // R3/R4/R6 sweep of channel-access limit against busy results, no ack request
    for (int mca = 0; mca < 8; mca++)
      for (int be = 0; be < 7; be++)
        run_txn(2, mca, be, 0, 0, 0, 6, ((mca + be) % 2) == 1);

    // R7/R8/R10 sweep of frame-retry limit against acknowledging attempt
    for (int mfr = 0; mfr < 4; mfr++)
      for (int aa = 0; aa <= mfr + 2; aa++)
        for (int p = 0; p < 2; p++)
          run_txn(mfr, 3, aa % 2, aa, p[0], 1, 6, p == 1);

    // R9 window boundary: ack in the expiry cycle wins, one later is too late
    run_txn(1, 2, 0, 1, 1, 1, T, 0);
    run_txn(1, 2, 0, 1, 0, 1, T + 1, 1);
    run_txn(2, 2, 1, 2, 1, 1, T, 1);
    run_txn(0, 2, 0, 1, 1, 1, T + 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule